// File: doc/BRIEF.md
# Wavefront Instruction Issue Scheduler

This block picks, every clock cycle, the instructions that a compute unit starts. The unit holds several SIMD groups, and each group has a fixed number of wavefront slots. For each slot the surrounding logic reports whether the slot holds a wavefront, whether that wavefront can issue, and the kind of its next instruction. A separate flag for each instruction kind says whether the shared unit that serves that kind is busy. The scheduler looks at one SIMD group per cycle and moves through the groups in a fixed rotation. Within the group in focus it grants at most one wavefront for each instruction kind. It never grants two instructions to the same wavefront, and it never starts more than a set number of instructions in one cycle.

Grants come out of registers and each one lasts a single cycle. The outputs are plain pulses, not valid/ready streams. The consumer must act on a grant in the cycle it appears, and the block has no back-pressure input. Flow control works the other way round. When a consumer cannot take work, it raises the busy flag for its instruction kind before the decision. A wavefront that is not ready simply drops its ready flag.

Within one group and one instruction kind, the scheduler keeps its own rotating start pointer. The wavefront granted least recently therefore goes first. A group is visited again every NUM_SIMD cycles, which matches the four cycles a vector instruction needs to pass through a SIMD group.

Top module: `wis_issue_sched`

## Requirements
- R1: While reset is asserted, every grant_vld bit is 0. The first decision after reset is released serves SIMD 0. Reset also returns every per-kind start pointer to slot 0.
- R2: The group in focus advances by one every cycle and wraps from NUM_SIMD-1 to 0. grant_simd reports the group that the current grants belong to. Slots of groups that are not in focus are never granted in that cycle.
- R3: A slot with wave_valid low or wave_ready low never receives a grant.
- R4: Kind codes are 0 vector ALU, 1 vector memory, 2 scalar, 3 branch, 4 local data share, 5 export or global data share, and 6 special. grant_vld[k] grants at most one slot for kind k, and that slot's reported kind is k.
- R5: One slot receives at most one grant per cycle, so the wave indices of simultaneous grants all differ.
- R6: When unit_busy[k] is high in a decision cycle, kind k gets no grant from that decision. Other kinds are unaffected.
- R7: At most MAX_ISSUE (default 5) grants are made per cycle. When more kinds are eligible, the kinds with the lowest codes win.
- R8: For each group and each kind, the search starts at the slot after the last slot granted for that pair and wraps around. Eligible slots of one kind are therefore served in rotating order.
- R9: Grants appear on the clock edge after the inputs they answer are sampled. Each grant lasts exactly one cycle unless a new decision renews it.
- R10: A slot reporting kind code 7 is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wave_valid | input | NUM_SIMD*WAVES | Slot holds a wavefront; bit s*WAVES+w is slot w of group s |
| wave_ready | input | NUM_SIMD*WAVES | Wavefront in the slot can issue its next instruction |
| wave_type | input | NUM_SIMD*WAVES*3 | Kind code of the next instruction, 3 bits per slot, same slot order |
| unit_busy | input | 7 | Shared unit for kind k is busy this cycle |
| grant_vld | output | 7 | Bit k: an instruction of kind k is issued this cycle |
| grant_wave | output | 7*WW | Slot index granted for kind k at bits k*WW +: WW (WW = clog2(WAVES)) |
| grant_simd | output | clog2(NUM_SIMD) | Group the current grants belong to |

## Verification
The bench places eligible wavefronts only on groups out of focus. A scheduler that ignored the rotation, or looked at the wrong group, would grant them too early. It offers one wavefront of every kind at once, so a scheduler without the issue cap would grant six or seven kinds, and one that ranked the kinds wrongly would drop vector ALU or vector memory. Three wavefronts of one kind are revisited until the grants have gone round, and a stuck or mis-advanced pointer would repeat one slot. Invalid, not-ready, busy-gated and kind-7 slots are offered next to an eligible slot, to catch a grant leaking through any of the gates.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int NUM_TYPES = 7;
  localparam int TYPE_W    = 3;

  typedef enum logic [TYPE_W-1:0] {
    OP_VALU    = 3'd0,
    OP_VMEM    = 3'd1,
    OP_SALU    = 3'd2,
    OP_BRANCH  = 3'd3,
    OP_LDS     = 3'd4,
    OP_GDS     = 3'd5,
    OP_SPECIAL = 3'd6,
    OP_NONE    = 3'd7
  } op_kind_e;
endpackage

// File: rtl/wis_focus_rotor.sv
module wis_focus_rotor #(
  parameter int NUM_SIMD = 4,
  parameter int SW       = 2
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] focus
);
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) focus <= '0;
    else if (focus == SW'(NUM_SIMD - 1)) focus <= '0;
    else focus <= focus + 1'b1;
  end

  // R2: the focus moves one group per cycle, wrapping at the last group
  assert_focus_step_R2: assert property (@(posedge clk) disable iff (rst || rst_q)
    focus == (($past(focus) == SW'(NUM_SIMD - 1)) ? SW'(0) : SW'($past(focus) + 1'b1)));
endmodule

// File: rtl/wis_slot_arbiter.sv
module wis_slot_arbiter #(
  parameter int N  = 10,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    int pos;
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      pos = int'(start) + k;
      if (pos >= N) pos = pos - N;
      if (!found && req[pos]) begin
        found = 1'b1;
        idx   = IW'(pos);
      end
    end
  end
endmodule

// File: rtl/wis_issue_limiter.sv
module wis_issue_limiter #(
  parameter int NT        = 7,
  parameter int MAX_ISSUE = 5
) (
  input  logic [NT-1:0] cand,
  output logic [NT-1:0] issue
);
  always_comb begin
    int cnt;
    cnt   = 0;
    issue = '0;
    for (int t = 0; t < NT; t++) begin
      if (cand[t] && cnt < MAX_ISSUE) begin
        issue[t] = 1'b1;
        cnt      = cnt + 1;
      end
    end
  end
endmodule

// File: rtl/wis_issue_sched.sv
module wis_issue_sched
  import wis_pkg::*;
#(
  parameter int NUM_SIMD  = 4,
  parameter int WAVES     = 10,
  parameter int MAX_ISSUE = 5,
  localparam int SW       = $clog2(NUM_SIMD),
  localparam int WW       = $clog2(WAVES),
  localparam int SLOTS    = NUM_SIMD * WAVES
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SLOTS-1:0]         wave_valid,
  input  logic [SLOTS-1:0]         wave_ready,
  input  logic [SLOTS*TYPE_W-1:0]  wave_type,
  input  logic [NUM_TYPES-1:0]     unit_busy,
  output logic [NUM_TYPES-1:0]     grant_vld,
  output logic [NUM_TYPES*WW-1:0]  grant_wave,
  output logic [SW-1:0]            grant_simd
);
  logic [SW-1:0] focus;

  wis_focus_rotor #(.NUM_SIMD(NUM_SIMD), .SW(SW)) u_rotor (
    .clk   (clk),
    .rst   (rst),
    .focus (focus)
  );

  // slots of the group in focus
  logic [WAVES-1:0]  sel_ok;
  logic [TYPE_W-1:0] sel_kind [WAVES];

  always_comb begin
    for (int w = 0; w < WAVES; w++) begin
      sel_ok[w]   = wave_valid[int'(focus)*WAVES + w] & wave_ready[int'(focus)*WAVES + w];
      sel_kind[w] = wave_type[(int'(focus)*WAVES + w)*TYPE_W +: TYPE_W];
    end
  end

  logic [WW-1:0]        ptr_q [NUM_SIMD][NUM_TYPES];
  logic [NUM_TYPES-1:0] found;
  logic [NUM_TYPES-1:0] issue;
  logic [WW-1:0]        pick  [NUM_TYPES];

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_kind
    logic [WAVES-1:0] req;

    always_comb begin
      for (int w = 0; w < WAVES; w++)
        req[w] = sel_ok[w] && (sel_kind[w] == TYPE_W'(t)) && !unit_busy[t];
    end

    wis_slot_arbiter #(.N(WAVES), .IW(WW)) u_arb (
      .req   (req),
      .start (ptr_q[focus][t]),
      .found (found[t]),
      .idx   (pick[t])
    );
  end

  wis_issue_limiter #(.NT(NUM_TYPES), .MAX_ISSUE(MAX_ISSUE)) u_limit (
    .cand  (found),
    .issue (issue)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_vld  <= '0;
      grant_wave <= '0;
      grant_simd <= '0;
      for (int s = 0; s < NUM_SIMD; s++)
        for (int t = 0; t < NUM_TYPES; t++)
          ptr_q[s][t] <= '0;
    end else begin
      grant_vld  <= issue;
      grant_simd <= focus;
      for (int t = 0; t < NUM_TYPES; t++) begin
        grant_wave[t*WW +: WW] <= issue[t] ? pick[t] : '0;
        if (issue[t])
          ptr_q[focus][t] <= (pick[t] == WW'(WAVES - 1)) ? '0 : pick[t] + 1'b1;
      end
    end
  end

  // R7: issue cap per cycle
  assert_issue_cap_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(grant_vld) <= MAX_ISSUE);

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_chk
    // R3: granted slot was valid and ready when the decision was taken
    assert_slot_eligible_R3: assert property (@(posedge clk) disable iff (rst)
      grant_vld[t] |->
        ((($past(wave_valid) & $past(wave_ready)) >>
          (int'(grant_simd)*WAVES + int'(grant_wave[t*WW +: WW]))) & SLOTS'(1)) == SLOTS'(1));
    // R4: granted slot reported this kind
    assert_kind_match_R4: assert property (@(posedge clk) disable iff (rst)
      grant_vld[t] |->
        TYPE_W'($past(wave_type) >>
          ((int'(grant_simd)*WAVES + int'(grant_wave[t*WW +: WW]))*TYPE_W)) == TYPE_W'(t));
    // R6: a busy unit blocks its kind
    assert_busy_block_R6: assert property (@(posedge clk) disable iff (rst)
      grant_vld[t] |-> !$past(unit_busy[t]));
    for (genvar u = t + 1; u < NUM_TYPES; u++) begin : g_pair
      // R5: one grant per wavefront
      assert_wave_once_R5: assert property (@(posedge clk) disable iff (rst)
        (grant_vld[t] && grant_vld[u]) |->
          grant_wave[t*WW +: WW] != grant_wave[u*WW +: WW]);
    end
  end
endmodule

// File: tb/test_wis_issue_sched.sv
module test_wis_issue_sched;
  import wis_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NW = 10;
  localparam int WW = 4;
  localparam int NT = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS*NW-1:0]        v;
  logic [NS*NW-1:0]        r;
  logic [NS*NW*TYPE_W-1:0] ty;
  logic [NT-1:0]           busy;
  logic [NT-1:0]           gv;
  logic [NT*WW-1:0]        gw;
  logic [1:0]              gs;

  int checks = 0;
  int fails  = 0;
  int fmod   = 0;
  int fused  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wis_issue_sched i_wis_issue_sched (
    .clk(clk), .rst(rst), .wave_valid(v), .wave_ready(r), .wave_type(ty),
    .unit_busy(busy), .grant_vld(gv), .grant_wave(gw), .grant_simd(gs)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    v = '0; r = '0; ty = '0; busy = '0;
  endtask

  task automatic set_slot(input int s, input int w, input bit val, input bit rdy, input int k);
    v[s*NW+w] = val;
    r[s*NW+w] = rdy;
    ty[(s*NW+w)*TYPE_W +: TYPE_W] = TYPE_W'(k);
  endtask

  // one decision edge, then return at the following falling edge
  task automatic step();
    @(posedge clk);
    fused = fmod;
    fmod  = (fmod + 1) % NS;
    @(negedge clk);
  endtask

  function automatic int wave_of(input int k);
    return int'(gw[k*WW +: WW]);
  endfunction

  task automatic t_reset();
    clear_all();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(gv == '0, "R1 grants in reset", int'(gv), 0);
    rst  = 1'b0;
    fmod = 0;
    set_slot(0, 4, 1, 1, OP_SALU);
    step();
    check(gs == 2'd0, "R1 first focus", int'(gs), 0);
    check(gv == 7'b0000100 && wave_of(OP_SALU) == 4, "R1 first grant on group 0", int'(gv), 4);
    clear_all();
  endtask

  task automatic t_focus();
    for (int i = 0; i < 8; i++) begin
      step();
      check(int'(gs) == fused, "R2 focus sequence", int'(gs), fused);
      check(gv == '0, "R9 grant lasts one cycle", int'(gv), 0);
    end
  endtask

  task automatic t_off_focus();
    int tgt;
    tgt = (fmod + 2) % NS;
    set_slot(tgt, 6, 1, 1, OP_BRANCH);
    step();
    check(gv == '0, "R2 off-focus slot ignored", int'(gv), 0);
    step();
    check(gv == '0, "R2 off-focus slot ignored", int'(gv), 0);
    step();
    check(gv == 7'b0001000 && wave_of(OP_BRANCH) == 6 && int'(gs) == tgt,
          "R2 slot granted in its own turn", wave_of(OP_BRANCH), 6);
    clear_all();
  endtask

  task automatic t_gates();
    int s;
    s = fmod;
    set_slot(s, 0, 1, 0, OP_VALU);
    set_slot(s, 1, 0, 1, OP_VALU);
    set_slot(s, 2, 1, 1, OP_NONE);
    set_slot(s, 3, 1, 1, OP_LDS);
    set_slot(s, 7, 1, 1, OP_VMEM);
    busy[OP_LDS] = 1'b1;
    step();
    check(gv[OP_VALU] == 1'b0, "R3 not-ready or invalid slot", int'(gv[OP_VALU]), 0);
    check(gv[OP_LDS] == 1'b0, "R6 busy unit blocks kind", int'(gv[OP_LDS]), 0);
    check(gv == 7'b0000010 && wave_of(OP_VMEM) == 7, "R6 other kinds still issue", int'(gv), 2);
    check(wave_of(OP_VALU) != 2, "R10 kind 7 never granted", wave_of(OP_VALU), 0);
    clear_all();
  endtask

  task automatic t_cap();
    int s;
    int cnt;
    bit uniq;
    s = fmod;
    for (int k = 0; k < NT; k++) set_slot(s, 9 - k, 1, 1, k);
    step();
    cnt = $countones(gv);
    check(cnt == 5, "R7 issue cap", cnt, 5);
    check(gv == 7'b0011111, "R7 lowest codes win", int'(gv), 31);
    for (int k = 0; k < 5; k++)
      check(wave_of(k) == 9 - k, "R4 kind matches slot", wave_of(k), 9 - k);
    uniq = 1;
    for (int a = 0; a < 5; a++)
      for (int b = a + 1; b < 5; b++)
        if (wave_of(a) == wave_of(b)) uniq = 0;
    check(uniq, "R5 distinct waves", int'(uniq), 1);
    clear_all();
    step();
    check(gv == '0, "R9 grant lasts one cycle", int'(gv), 0);
  endtask

  function automatic int next_in_set(input int cur);
    if (cur == 2) return 5;
    if (cur == 5) return 8;
    return 2;
  endfunction

  task automatic t_rotate();
    int s;
    int prev;
    int g;
    s = fmod;
    set_slot(s, 2, 1, 1, OP_VMEM);
    set_slot(s, 5, 1, 1, OP_VMEM);
    set_slot(s, 8, 1, 1, OP_VMEM);
    step();
    g = wave_of(OP_VMEM);
    check(gv == 7'b0000010 && (g == 2 || g == 5 || g == 8), "R8 first pick in set", g, 2);
    prev = g;
    for (int i = 0; i < 4; i++) begin
      repeat (NS - 1) step();
      step();
      g = wave_of(OP_VMEM);
      check(gv[OP_VMEM] && g == next_in_set(prev), "R8 rotating order", g, next_in_set(prev));
      prev = g;
    end
    clear_all();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_all();
    t_reset();
    t_focus();
    t_off_focus();
    t_gates();
    t_cap();
    t_rotate();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule